// File: doc/BRIEF.md
# Standby Power Mode Controller

This block sits beside a microcontroller core and decides which clocks run. There are three low-power modes. In the idle-CPU mode the core clock stops and the peripheral clock keeps running. In the bus-release mode an external master takes the bus while the core clock is stopped. In the deep-sleep mode both clocks stop, and the main oscillator can also be shut down. Firmware selects a mode by writing to three small registers through a single write port. An external request pin, interrupt lines and a watchdog overflow bring the core back.

Deep sleep has a guard. A write that requests it takes effect only after a two-step unlock written to a separate code register. When the oscillator was shut down during deep sleep, the block holds both clocks off for a programmable restart wait before it lets them run again.

Top module: `stby_ctrl`

## Requirements
- R1: After the reset pin is asserted, cpu_clk_en, per_clk_en and osc_en are 1, and out_float and hold_ack are 0. All register bits are cleared.
- R2: Writing the mode register (wr_sel=0) with bit 1 set arms idle-CPU mode. The mode is entered on the next cycle where instr_end is 1. From the following cycle cpu_clk_en is 0 and per_clk_en stays 1.
- R3: In idle-CPU mode, a 1 on any bit of irq returns cpu_clk_en to 1 in the next cycle.
- R4: The unlock completes only after two code-register writes (wr_sel=1) in a row. The first has low nibble 5h and the second has low nibble Ah. The high nibble of each may be any value. Any other value written to the code register returns the unlock to its start state.
- R5: A mode-register write with bit 0 set while the unlock is incomplete is ignored, and both clocks stay enabled.
- R6: A mode-register write with bit 0 set after the unlock enters deep sleep in the next cycle. In deep sleep cpu_clk_en and per_clk_en are 0, osc_en is the inverse of bit 3, and out_float equals bit 2.
- R7: If bit 3 was 0, an irq in deep sleep re-enables both clocks in the next cycle.
- R8: If bit 3 was 1, an irq in deep sleep raises osc_en at once and keeps both clocks off for exactly 2^(OST_BASE_LOG+2*k) cycles, where k is mode-register bits 5:4. The default OST_BASE_LOG of 10 gives 2^10 to 2^16 cycles.
- R9: Entering deep sleep uses up the unlock, so a later deep-sleep request needs a fresh unlock.
- R10: The hold pin is ignored while bit 5 of the peripheral register (wr_sel=2) is 0.
- R11: With the enable set, a high hold pin drops cpu_clk_en in the next cycle, and hold_ack rises one cycle later. per_clk_en stays 1.
- R12: When the hold pin goes low, hold_ack falls in the same cycle that cpu_clk_en rises.
- R13: wdt_ovf acts as a reset. It leaves any mode and clears all register bits, including the hold enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Reset pin, active low, asynchronous |
| wdt_ovf | input | 1 | Watchdog overflow, synchronous reset |
| irq | input | IRQ_W | Interrupt requests |
| instr_end | input | 1 | Instruction boundary strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 mode, 1 code, 2 peripheral |
| wr_data | input | 8 | Write data |
| hold_in | input | 1 | External bus-release request |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| out_float | output | 1 | Float output pads |
| hold_ack | output | 1 | Bus-release acknowledge |

## Verification
The bench sweeps every combination of float bit, oscillator bit and wait code, with a different high nibble in the unlock writes each time. It measures the restart wait to the exact cycle. A counter off by one, or a shift built from the wrong base, would show up as a wait that is a cycle or a power of two off. The bench also tries a broken unlock (5h, other, Ah) and a second deep-sleep request that skips the unlock. A design that does not reset or consume the unlock would go to sleep in one of these cases. Idle-CPU entry is checked before and after the instruction boundary, and a design that halted on the write itself would fail there. The bus-release sequence is checked on each cycle, so an acknowledge raised together with the clock gate, or dropped a cycle late, is reported.

// File: rtl/stby_pkg.sv
package stby_pkg;
    typedef enum logic [2:0] {
        ST_RUN, ST_HALT, ST_STOP, ST_STAB, ST_HENT, ST_HOLD
    } stby_st_e;

    localparam logic [1:0] SEL_MODE = 2'd0;
    localparam logic [1:0] SEL_CODE = 2'd1;
    localparam logic [1:0] SEL_PERI = 2'd2;

    localparam int B_SLEEP = 0;
    localparam int B_IDLE  = 1;
    localparam int B_FLOAT = 2;
    localparam int B_OSCOFF = 3;
    localparam int B_WAIT  = 4;
    localparam int B_HOLDEN = 5;

    typedef struct packed {
        stby_st_e   st;
        logic       idle_arm;
        logic       flt;
        logic       oscoff;
        logic [1:0] wsel;
        logic       hold_en;
    } stby_reg_s;
endpackage

// File: rtl/stby_unlock.sv
module stby_unlock (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       wr,
    input  logic [3:0] nib,
    output logic       ready
);
    typedef enum logic [1:0] {U_IDLE, U_HALF, U_OPEN} unl_e;
    unl_e u_q, u_d;

    always_comb begin
        u_d = u_q;
        if (clr) begin
            u_d = U_IDLE;
        end else if (wr) begin
            if (u_q == U_HALF && nib == 4'hA) u_d = U_OPEN;
            else if (u_q != U_HALF && nib == 4'h5) u_d = U_HALF;
            else u_d = U_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) u_q <= U_IDLE;
        else        u_q <= u_d;
    end

    assign ready = (u_q == U_OPEN);

    a_r4_open_after_second_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(wr && nib == 4'hA));
endmodule

// File: rtl/stby_stab_timer.sv
module stby_stab_timer #(
    parameter int OST_BASE_LOG = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       start,
    input  logic [1:0] wsel,
    output logic       done
);
    localparam int CW = OST_BASE_LOG + 7;

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } tmr_s;
    tmr_s t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (clr) begin
            t_d = '0;
        end else if (start) begin
            t_d.act = 1'b1;
            t_d.cnt = (CW'(1) << (OST_BASE_LOG + 2 * int'(wsel))) - CW'(1);
        end else if (t_q.act) begin
            if (t_q.cnt == '0) t_d.act = 1'b0;
            else               t_d.cnt = t_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign done = t_q.act && (t_q.cnt == '0);

    a_r8_count_descends: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(t_q.act) && t_q.act && !$past(start) && !$past(clr)) |-> (t_q.cnt == $past(t_q.cnt) - CW'(1)));
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl #(
    parameter int IRQ_W        = 8,
    parameter int OST_BASE_LOG = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_ovf,
    input  logic [IRQ_W-1:0] irq,
    input  logic             instr_end,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             hold_in,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             out_float,
    output logic             hold_ack
);
    import stby_pkg::*;

    stby_reg_s r_q, r_d;
    logic unl_ok, unl_clr, stab_start, stab_done, any_irq, sleep_go;

    assign any_irq = |irq;

    stby_unlock i_unlock (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (unl_clr),
        .wr    (wr_en && wr_sel == SEL_CODE && r_q.st == ST_RUN),
        .nib   (wr_data[3:0]),
        .ready (unl_ok)
    );

    stby_stab_timer #(.OST_BASE_LOG(OST_BASE_LOG)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wdt_ovf),
        .start (stab_start),
        .wsel  (r_q.wsel),
        .done  (stab_done)
    );

    always_comb begin
        r_d        = r_q;
        unl_clr    = 1'b0;
        stab_start = 1'b0;
        sleep_go   = 1'b0;
        if (wr_en && r_q.st == ST_RUN) begin
            if (wr_sel == SEL_MODE) begin
                r_d.flt    = wr_data[B_FLOAT];
                r_d.oscoff = wr_data[B_OSCOFF];
                r_d.wsel   = wr_data[B_WAIT +: 2];
                if (wr_data[B_IDLE]) r_d.idle_arm = 1'b1;
                sleep_go = wr_data[B_SLEEP] && unl_ok;
            end else if (wr_sel == SEL_PERI) begin
                r_d.hold_en = wr_data[B_HOLDEN];
            end
        end
        unique case (r_q.st)
            ST_RUN: begin
                if (sleep_go) begin
                    r_d.st       = ST_STOP;
                    r_d.idle_arm = 1'b0;
                    unl_clr      = 1'b1;
                end else if (r_q.idle_arm && instr_end) begin
                    r_d.st = ST_HALT;
                end else if (hold_in && r_q.hold_en) begin
                    r_d.st = ST_HENT;
                end
            end
            ST_HALT: begin
                if (any_irq) begin
                    r_d.st       = ST_RUN;
                    r_d.idle_arm = 1'b0;
                end
            end
            ST_STOP: begin
                if (any_irq) begin
                    r_d.idle_arm = 1'b0;
                    unl_clr      = 1'b1;
                    if (r_q.oscoff) begin
                        r_d.st     = ST_STAB;
                        stab_start = 1'b1;
                    end else begin
                        r_d.st = ST_RUN;
                    end
                end
            end
            ST_STAB: if (stab_done) r_d.st = ST_RUN;
            ST_HENT: r_d.st = hold_in ? ST_HOLD : ST_RUN;
            ST_HOLD: if (!hold_in) r_d.st = ST_RUN;
            default: r_d.st = ST_RUN;
        endcase
        if (wdt_ovf) begin
            r_d        = '0;
            r_d.st     = ST_RUN;
            unl_clr    = 1'b1;
            stab_start = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_RUN;
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_clk_en = (r_q.st == ST_RUN);
    assign per_clk_en = !(r_q.st == ST_STOP || r_q.st == ST_STAB);
    assign osc_en     = !(r_q.st == ST_STOP && r_q.oscoff);
    assign out_float  = (r_q.st == ST_STOP) && r_q.flt;
    assign hold_ack   = (r_q.st == ST_HOLD);

    a_r5_sleep_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_STOP) |-> $past(unl_ok));
    a_r8_wait_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st == ST_STAB) && r_q.st == ST_RUN && !$past(wdt_ovf)) |-> $past(stab_done));
    a_r11_ack_after_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> $past(!cpu_clk_en));
    a_r6_float_while_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        out_float |-> (!per_clk_en && !cpu_clk_en));
    a_r6_osc_off_while_asleep: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> !per_clk_en);
    a_r12_ack_exit_restores_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_ack) && !$past(wdt_ovf)) |-> cpu_clk_en);
endmodule

// File: tb/test_stby_ctrl.sv
module test_stby_ctrl;
    localparam int IRQ_W = 4;
    localparam int BASE  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wdt_ovf = 1'b0;
    logic [IRQ_W-1:0] irq = '0;
    logic instr_end = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic hold_in = 1'b0;
    logic cpu_clk_en, per_clk_en, osc_en, out_float, hold_ack;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    stby_ctrl #(.IRQ_W(IRQ_W), .OST_BASE_LOG(BASE)) i_stby_ctrl (
        .clk(clk), .rst_n(rst_n), .wdt_ovf(wdt_ovf), .irq(irq),
        .instr_end(instr_end), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .hold_in(hold_in), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_en(osc_en), .out_float(out_float),
        .hold_ack(hold_ack)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic pulse_irq(input int b);
        irq[b] = 1'b1;
        step();
        irq = '0;
    endtask

    task automatic unlock(input logic [3:0] hi);
        wr(2'd1, {hi, 4'h5});
        wr(2'd1, {~hi, 4'hA});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step();
        step();
        // R1 reset values
        chk("R1 cpu", cpu_clk_en, 1); chk("R1 per", per_clk_en, 1);
        chk("R1 osc", osc_en, 1); chk("R1 float", out_float, 0);
        chk("R1 ack", hold_ack, 0);
        rst_n = 1'b1;
        step();

        // R2 / R3: idle mode, woken by each irq bit
        for (int b = 0; b < IRQ_W; b++) begin
            wr(2'd0, 8'h02);
            step();
            chk("R2 waits boundary", cpu_clk_en, 1);
            instr_end = 1'b1; step(); instr_end = 1'b0;
            chk("R2 cpu off", cpu_clk_en, 0);
            chk("R2 per on", per_clk_en, 1);
            step(); step();
            chk("R2 stays idle", cpu_clk_en, 0);
            pulse_irq(b);
            chk("R3 irq wakes", cpu_clk_en, 1);
            instr_end = 1'b1; step(); instr_end = 1'b0;
            chk("R3 arm cleared", cpu_clk_en, 1);
        end

        // R13 watchdog leaves idle mode
        wr(2'd0, 8'h02);
        instr_end = 1'b1; step(); instr_end = 1'b0;
        wdt_ovf = 1'b1; step(); wdt_ovf = 1'b0;
        chk("R13 wdt wakes idle", cpu_clk_en, 1);

        // R5 sleep without unlock
        wr(2'd0, 8'h01);
        chk("R5 no unlock", per_clk_en, 1);
        // R4 broken sequence
        wr(2'd1, 8'h35); wr(2'd1, 8'h33); wr(2'd1, 8'h4A);
        wr(2'd0, 8'h01);
        chk("R4 broken unlock", per_clk_en, 1);

        // R6 / R7 / R8 sweep over float, oscillator and wait code
        for (int c = 0; c < 16; c++) begin
            logic fl, oo;
            logic [1:0] w;
            int k;
            fl = c[0]; oo = c[1]; w = c[3:2];
            unlock(c[3:0]);
            wr(2'd0, {2'b00, w, oo, fl, 2'b01});
            chk("R6 cpu off", cpu_clk_en, 0);
            chk("R6 per off", per_clk_en, 0);
            chk("R6 osc", osc_en, int'(!oo));
            chk("R6 float", out_float, int'(fl));
            step();
            chk("R6 stays asleep", per_clk_en, 0);
            pulse_irq(c % IRQ_W);
            if (!oo) begin
                chk("R7 fast wake cpu", cpu_clk_en, 1);
                chk("R7 fast wake per", per_clk_en, 1);
            end else begin
                chk("R8 osc restarts", osc_en, 1);
                chk("R8 float released", out_float, 0);
                chk("R8 per held", per_clk_en, 0);
                k = 0;
                while (!cpu_clk_en && k < 20000) begin step(); k++; end
                chk("R8 wait length", k, 1 << (BASE + 2 * int'(w)));
                chk("R8 per back", per_clk_en, 1);
            end
            // R9 unlock used up
            wr(2'd0, 8'h01);
            chk("R9 unlock consumed", per_clk_en, 1);
        end

        // R13 watchdog ends sleep
        unlock(4'h0);
        wr(2'd0, 8'h09);
        chk("R13 asleep", osc_en, 0);
        wdt_ovf = 1'b1; step(); wdt_ovf = 1'b0;
        chk("R13 wdt wakes sleep", cpu_clk_en, 1);
        chk("R13 osc on", osc_en, 1);

        // R10 hold ignored without enable
        hold_in = 1'b1;
        step(); step();
        chk("R10 ignored cpu", cpu_clk_en, 1);
        chk("R10 ignored ack", hold_ack, 0);
        hold_in = 1'b0;
        step();
        wr(2'd2, 8'h20);
        hold_in = 1'b1; step();
        chk("R11 cpu gated", cpu_clk_en, 0);
        chk("R11 ack not yet", hold_ack, 0);
        chk("R11 per on", per_clk_en, 1);
        step();
        chk("R11 ack set", hold_ack, 1);
        step();
        chk("R11 ack held", hold_ack, 1);
        hold_in = 1'b0; step();
        chk("R12 ack drop", hold_ack, 0);
        chk("R12 cpu back", cpu_clk_en, 1);

        // R13 watchdog clears hold enable
        wdt_ovf = 1'b1; step(); wdt_ovf = 1'b0;
        hold_in = 1'b1; step(); step();
        chk("R13 hold enable cleared", cpu_clk_en, 1);
        chk("R13 no ack", hold_ack, 0);
        hold_in = 1'b0;
        step();

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule